// File: doc/BRIEF.md
# Page Replacement Victim Selector

This block keeps the page tags resident in a small fixed set of frames. For every page reference it reports whether the page was resident, which frame serves it, and whether a resident page had to be evicted. A reference to a page that is not resident fills the lowest-numbered empty frame. If no frame is empty, the block picks a victim under one of three policies chosen at the policy input: oldest arrival, least recently used, or fewest uses since the frame was loaded.

Per-frame policy state is a single key per frame. The key is an arrival stamp, a last-use stamp or a use count, depending on the policy. The victim is always the frame with the smallest key. Running totals of faults and evictions are provided so that a whole reference string can be judged at once. The block moves no data. It only decides where data should go.

Top module: `page_victim_sel`

## Requirements
- R1: While rst_n is low at a clock edge, every frame becomes empty, both totals become 0, and resp_valid_o, hit_o, fault_o and replaced_o become 0.
- R2: A reference sampled with ref_valid_i high at a clock edge is answered by outputs updated at that same edge. A cycle with ref_valid_i low leaves resp_valid_o, hit_o, fault_o and replaced_o at 0 in the following cycle.
- R3: A reference to a page held in a frame gives hit_o=1, fault_o=0 and replaced_o=0, with frame_o naming that frame.
- R4: A reference to a non-resident page while an empty frame exists gives fault_o=1 and replaced_o=0, and loads the page into the lowest-indexed empty frame.
- R5: With policy_i = 0 (and also with the spare code 3), a fault with all frames full evicts the frame whose page was loaded earliest. Hits do not change this order.
- R6: With policy_i = 1, a fault with all frames full evicts the frame referenced least recently, counting both loads and hits.
- R7: With policy_i = 2, a frame's count becomes 1 when a page is loaded into it and rises by 1 on each hit to it. A fault with all frames full evicts the frame with the lowest count, taking the lowest index on a tie.
- R8: fault_count_o rises by 1 for every fault. repl_count_o rises by 1 for every fault that evicts a resident page. Hits change neither total.
- R9: With 4 frames, the reference string 1 2 3 4 1 2 5 1 2 3 4 5 gives 10 faults and 6 evictions under policy 0, 8 and 4 under policy 1, and 7 and 3 under policy 2.
- R10: After a reset, a page that was resident before the reset faults and is loaded into frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Policy code: 0 oldest arrival, 1 least recent, 2 fewest uses, 3 as 0; held between resets |
| ref_valid_i | input | 1 | A page reference is presented this cycle |
| ref_page_i | input | PAGE_W | Page number referenced |
| resp_valid_o | output | 1 | Response for the reference of the previous cycle |
| hit_o | output | 1 | Page was resident |
| fault_o | output | 1 | Page was not resident |
| replaced_o | output | 1 | A resident page was evicted |
| frame_o | output | clog2(NUM_FRAMES) | Frame that now holds the page |
| fault_count_o | output | CNT_W | Faults since reset |
| repl_count_o | output | CNT_W | Evictions since reset |

## Verification
The hardest situation to reach is a count tie under the fewest-uses policy where both the tie and its lowest-index resolution decide the result. This happens when a frame that was just refilled has its count reset to 1 and stays tied with an older frame that was never hit. The classic reference string reaches this case twice, so the bench runs it under every policy. It then runs a longer pseudo-random string over more pages than frames, with idle gaps, to reach many evictions. A reset in the middle of a run shows that residency is cleared.

// File: rtl/pvs_pkg.sv
// Shared policy encoding for the page victim selector.
package pvs_pkg;
    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_LRU  = 2'd1,
        POL_LFU  = 2'd2,
        POL_SPARE = 2'd3
    } policy_e;
endpackage

// File: rtl/pvs_tag_match.sv
// Compares a page against all frame tags and finds the first empty frame.
// Assumes at most one valid frame holds any given page (the parent guarantees it).
module pvs_tag_match #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0][PAGE_W-1:0] tags,
    input  logic [NUM_FRAMES-1:0]             valid,
    input  logic [PAGE_W-1:0]                 page,
    output logic [NUM_FRAMES-1:0]             hit_vec,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic                              any_free,
    output logic [IDX_W-1:0]                  free_idx
);
    // One comparator per frame.
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == page);
    end

    // Encode the matching frame and the lowest-indexed empty frame.
    always_comb begin
        hit      = |hit_vec;
        any_free = ~&valid;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx  = IDX_W'(i);
            if (!valid[i])  free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pvs_victim_pick.sv
// Returns the index of the frame with the smallest key; ties go to the lowest index.
// Assumes every frame is occupied when the result is used.
module pvs_victim_pick #(
    parameter int NUM_FRAMES = 4,
    parameter int KEY_W      = 16,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0][KEY_W-1:0] keys,
    output logic [IDX_W-1:0]                 victim_idx
);
    logic [KEY_W-1:0] best;

    // Linear minimum scan with a strict compare, so earlier frames win ties.
    always_comb begin
        best       = keys[0];
        victim_idx = '0;
        for (int i = 1; i < NUM_FRAMES; i++) begin
            if (keys[i] < best) begin
                best       = keys[i];
                victim_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/page_victim_sel.sv
// Page replacement victim selector: tracks resident pages per frame, answers each
// reference with hit/fault, frame and eviction, under an arrival, recency or use-count policy.
// Assumes policy_i only changes across a reset, and that fewer than 2**KEY_W references
// arrive between resets so stamps do not wrap.
module page_victim_sel
    import pvs_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int KEY_W      = 16,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy_i,
    input  logic              ref_valid_i,
    input  logic [PAGE_W-1:0] ref_page_i,
    output logic              resp_valid_o,
    output logic              hit_o,
    output logic              fault_o,
    output logic              replaced_o,
    output logic [IDX_W-1:0]  frame_o,
    output logic [CNT_W-1:0]  fault_count_o,
    output logic [CNT_W-1:0]  repl_count_o
);
    logic [NUM_FRAMES-1:0][PAGE_W-1:0] tag_q;
    logic [NUM_FRAMES-1:0]             vld_q;
    logic [NUM_FRAMES-1:0][KEY_W-1:0]  key_q;
    logic [KEY_W-1:0]                  stamp_q;
    logic [NUM_FRAMES-1:0]             hit_vec;
    logic                              hit_any, any_free, evict;
    logic [IDX_W-1:0]                  hit_idx, free_idx, victim_idx, tgt_idx;
    logic [KEY_W-1:0]                  tgt_key;
    policy_e                           pol;

    assign pol = policy_e'(policy_i);

    pvs_tag_match #(.NUM_FRAMES(NUM_FRAMES), .PAGE_W(PAGE_W)) u_match (
        .tags(tag_q), .valid(vld_q), .page(ref_page_i), .hit_vec(hit_vec),
        .hit(hit_any), .hit_idx(hit_idx), .any_free(any_free), .free_idx(free_idx)
    );

    pvs_victim_pick #(.NUM_FRAMES(NUM_FRAMES), .KEY_W(KEY_W)) u_pick (
        .keys(key_q), .victim_idx(victim_idx)
    );

    // Choose the frame to use and the key it will hold after this reference.
    always_comb begin
        evict   = !hit_any && !any_free;
        tgt_idx = hit_any ? hit_idx : (any_free ? free_idx : victim_idx);
        if (!hit_any) begin
            tgt_key = (pol == POL_LFU) ? KEY_W'(1) : stamp_q;
        end else begin
            case (pol)
                POL_LRU: tgt_key = stamp_q;
                POL_LFU: tgt_key = (&key_q[hit_idx]) ? key_q[hit_idx] : key_q[hit_idx] + KEY_W'(1);
                default: tgt_key = key_q[hit_idx];
            endcase
        end
    end

    // Frame residency, policy keys and the reference stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            vld_q   <= '0;
            key_q   <= '0;
            stamp_q <= '0;
        end else if (ref_valid_i) begin
            tag_q[tgt_idx] <= ref_page_i;
            vld_q[tgt_idx] <= 1'b1;
            key_q[tgt_idx] <= tgt_key;
            stamp_q        <= stamp_q + KEY_W'(1);
        end
    end

    // Registered response and running totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o  <= 1'b0;
            hit_o         <= 1'b0;
            fault_o       <= 1'b0;
            replaced_o    <= 1'b0;
            frame_o       <= '0;
            fault_count_o <= '0;
            repl_count_o  <= '0;
        end else begin
            resp_valid_o <= ref_valid_i;
            hit_o        <= ref_valid_i && hit_any;
            fault_o      <= ref_valid_i && !hit_any;
            replaced_o   <= ref_valid_i && evict;
            if (ref_valid_i) frame_o <= tgt_idx;
            if (ref_valid_i && !hit_any) fault_count_o <= fault_count_o + CNT_W'(1);
            if (ref_valid_i && evict)    repl_count_o  <= repl_count_o + CNT_W'(1);
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)) else $error("page held in two frames"); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid_o |-> !(hit_o || fault_o || replaced_o)) else $error("idle response"); // R2
    AST_EVICT_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        replaced_o |-> fault_o && !hit_o) else $error("eviction without fault"); // R4
    AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        replaced_o |-> $past(&vld_q)) else $error("eviction with free frame"); // R4
    AST_FAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && fault_o) |-> fault_count_o == $past(fault_count_o) + CNT_W'(1))
        else $error("fault total step"); // R8
    AST_HIT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && hit_o) |-> $stable(fault_count_o) && $stable(repl_count_o))
        else $error("hit changed totals"); // R8
    AST_LFU_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid_i && pol == POL_LFU && !hit_any) |=> key_q[$past(tgt_idx)] == KEY_W'(1))
        else $error("load count not one"); // R7
endmodule

// File: tb/page_victim_sel_test.sv
`timescale 1ns/1ps
module page_victim_sel_test;
    localparam int NF = 4;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy_i = 2'd0;
    logic       ref_valid_i = 1'b0;
    logic [7:0] ref_page_i = '0;
    logic       resp_valid_o, hit_o, fault_o, replaced_o;
    logic [1:0] frame_o;
    logic [15:0] fault_count_o, repl_count_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state (behavioural, queue based).
    int m_tag[NF];
    bit m_vld[NF];
    int m_cnt[NF];
    int fifo_q[$];
    int lru_q[$];
    int m_faults, m_repl;

    page_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .ref_valid_i(ref_valid_i),
        .ref_page_i(ref_page_i), .resp_valid_o(resp_valid_o), .hit_o(hit_o),
        .fault_o(fault_o), .replaced_o(replaced_o), .frame_o(frame_o),
        .fault_count_o(fault_count_o), .repl_count_o(repl_count_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NF; i++) begin
            m_tag[i] = 0; m_vld[i] = 0; m_cnt[i] = 0;
        end
        fifo_q.delete();
        lru_q.delete();
        m_faults = 0;
        m_repl = 0;
    endfunction

    function automatic void touch_lru(input int f);
        for (int k = 0; k < lru_q.size(); k++) begin
            if (lru_q[k] == f) begin
                lru_q.delete(k);
                break;
            end
        end
        lru_q.push_back(f);
    endfunction

    task automatic model_ref(input int page, input int pol, output bit e_hit,
                             output bit e_rep, output int e_frame);
        int f;
        f = -1;
        e_hit = 0;
        e_rep = 0;
        for (int i = 0; i < NF; i++) if (m_vld[i] && m_tag[i] == page) f = i;
        if (f >= 0) begin
            e_hit = 1;
            touch_lru(f);
            m_cnt[f]++;
        end else begin
            m_faults++;
            for (int i = NF - 1; i >= 0; i--) if (!m_vld[i]) f = i;
            if (f < 0) begin
                e_rep = 1;
                m_repl++;
                if (pol == 1) begin
                    f = lru_q.pop_front();
                end else if (pol == 2) begin
                    f = 0;
                    for (int i = 1; i < NF; i++) if (m_cnt[i] < m_cnt[f]) f = i;
                end else begin
                    f = fifo_q.pop_front();
                end
            end
            m_tag[f] = page;
            m_vld[f] = 1;
            m_cnt[f] = 1;
            for (int k = 0; k < fifo_q.size(); k++) if (fifo_q[k] == f) begin fifo_q.delete(k); break; end
            fifo_q.push_back(f);
            touch_lru(f);
        end
        e_frame = f;
    endtask

    function automatic string pol_tag(input int pol);
        if (pol == 1) return "R6";
        if (pol == 2) return "R7";
        return "R5";
    endfunction

    // One cycle: drive at negedge, compare 1 ns after the next rising edge.
    task automatic step(input bit v, input int page);
        bit e_hit, e_rep;
        int e_frame;
        @(negedge clk);
        ref_valid_i = v;
        ref_page_i = 8'(page);
        if (v) model_ref(page, int'(policy_i), e_hit, e_rep, e_frame);
        @(posedge clk);
        #1;
        chk("R2", "resp_valid", int'(resp_valid_o), int'(v));
        if (v) begin
            chk("R3", "hit", int'(hit_o), int'(e_hit));
            chk("R4", "fault", int'(fault_o), int'(!e_hit));
            chk(pol_tag(int'(policy_i)), "frame", int'(frame_o), e_frame);
            chk(pol_tag(int'(policy_i)), "replaced", int'(replaced_o), int'(e_rep));
        end else begin
            chk("R2", "idle flags", int'({hit_o, fault_o, replaced_o}), 0);
        end
        chk("R8", "fault total", int'(fault_count_o), m_faults);
        chk("R8", "evict total", int'(repl_count_o), m_repl);
        ref_valid_i = 0;
    endtask

    task automatic do_reset(input int pol);
        @(negedge clk);
        policy_i = 2'(pol);
        rst_n = 0;
        ref_valid_i = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        #1;
        // R1: cleared outputs and totals
        chk("R1", "flags after reset", int'({resp_valid_o, hit_o, fault_o, replaced_o}), 0);
        chk("R1", "totals after reset", int'(fault_count_o) + int'(repl_count_o), 0);
    endtask

    task automatic classic_string(input int pol, input int exp_f, input int exp_r);
        int s[12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
        do_reset(pol);
        for (int i = 0; i < 12; i++) begin
            step(1, s[i]);
            if (i == 5) step(0, 0);
        end
        chk("R9", "string fault total", int'(fault_count_o), exp_f);
        chk("R9", "string evict total", int'(repl_count_o), exp_r);
    endtask

    initial begin
        int lcg;
        repeat (2) @(posedge clk);
        classic_string(0, 10, 6);
        classic_string(1, 8, 4);
        classic_string(2, 7, 3);
        classic_string(3, 10, 6); // R5: spare code acts as oldest-arrival
        for (int p = 0; p < 3; p++) begin
            do_reset(p);
            lcg = 7 + p;
            for (int i = 0; i < 120; i++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
                step(1, (lcg >> 16) % 7);
                if (i % 5 == 4) step(0, 0);
            end
        end
        // R10: reset drops residency; page 3 faults into frame 0
        do_reset(1);
        step(1, 3);
        step(1, 3);
        do_reset(1);
        step(1, 3);
        chk("R10", "fault after reset", int'(fault_o), 1);
        chk("R10", "frame after reset", int'(frame_o), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule